// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is the data path of a small single-cycle processor core. It takes two 8-bit operands, an operation select and an enable, and forms the 8-bit result combinationally. It also computes the next value of the eight-bit status word. The status word is held in a register inside the block. Each operation changes only its own group of flags: arithmetic touches carry, zero, negative, overflow and half-carry; logic and increment/decrement touch only zero, negative and overflow; nibble swap touches nothing. Immediate forms of an operation reuse the same select code, with the constant presented on the second operand.

Compare operations go through the subtractor and update the flags, but they drop the result write enable. The carry-chained subtract and compare can only clear zero, never set it. This lets a multi-byte comparison or subtraction build its zero flag across bytes. The core may also load the whole status word directly, for example when it restores the word from memory.

Top module: `alu8_flags_unit`

## Requirements
- R1: `op_sel` codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 LSL, 12 LSR, 13 ROL, 14 ROR, 15 ASR, 16 SWAP, 17 CP, 18 CPC. Single-operand operations use `op_a`. Any other code passes `op_a` to `result`, changes no flag and holds `res_we` low.
- R2: Status bits, from bit 7 down to bit 0, are I, T, H, S, V, N, Z, C.
  - Reset clears the status register.
  - `st_load` loads `st_wdata`, and takes priority over `alu_en`.
  - `alu_en` loads `status_next`.
  - With neither asserted, the register holds its value.
- R3: ADD computes a+b, and ADC computes a+b+C. Both set:
  - C to the carry out of bit 7;
  - H to the carry out of bit 3;
  - V on signed overflow;
  - N to result bit 7;
  - Z when the result is zero.
- R4: SUB and CP compute a-b, and SBC and CPC compute a-b-C. All four set:
  - C on a borrow;
  - H on a borrow into bit 4;
  - V on signed overflow;
  - N from result bit 7;
  - Z (SUB and CP only) when the result is zero.
- R5: SBC and CPC clear Z when the result is nonzero, and otherwise leave Z at its previous value.
- R6: CP and CPC drive the difference on `result` but hold `res_we` low. Every other valid operation drives `res_we` high while `alu_en` is high.
- R7: AND, OR and XOR update Z and N and clear V. C and H keep their values.
- R8: INC and DEC add or subtract one and update Z, N and V. V is set only for 0x7F to 0x80 (INC) and 0x80 to 0x7F (DEC). C and H keep their values.
- R9: COM gives 0xFF-a, sets C, clears V, updates Z and N, and keeps H. NEG gives 0x00-a, sets C when a is nonzero, sets V only for a=0x80, sets H on a borrow into bit 4, and updates Z and N.
- R10: LSL shifts left with 0 into bit 0, and LSR shifts right with 0 into bit 7. For both, C takes the bit shifted out, V = N xor C, Z and N follow the result, and H is kept.
- R11: ROL moves C into bit 0 and bit 7 into C. ROR moves C into bit 7 and bit 0 into C. For both, V = N xor C, Z and N follow the result, and H is kept.
- R12: ASR keeps bit 7, shifts bits 7..1 down one place and puts bit 0 into C. V = N xor C, Z and N follow the result, and H is kept.
- R13: SWAP exchanges the two nibbles and changes no status bit.
- R14: Whenever an operation updates N or V, S becomes N xor V. No operation changes I or T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First operand (destination register value) |
| op_b | input | 8 | Second operand (register or immediate) |
| op_sel | input | 5 | Operation select |
| alu_en | input | 1 | Operation is executing this cycle; commit flags |
| st_load | input | 1 | Load the status register directly |
| st_wdata | input | 8 | Value for a direct status load |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result is to be written back |
| status_next | output | 8 | Status value the current operation would commit |
| status_q | output | 8 | Registered status word |

## Verification
The embedded properties assume `op_sel`, `alu_en` and `st_load` are stable across a clock edge and free of unknowns while reset is released. They also expect the flag properties to be meaningful only in cycles where `st_load` is low. The bench changes every input on the falling edge only. It keeps `st_load` low during operation cycles, except in the one scenario that tests load priority, and every property's antecedent excludes that case.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW  = 8;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_COM  = 5'd7,
    OP_NEG  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16,
    OP_CP   = 5'd17,
    OP_CPC  = 5'd18
  } alu_op_e;

  // status bit positions; the core relies on this order
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cy,
  output logic          hc,
  output logic          ov
);
  localparam int HB  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic          co_raw;
  logic          h_raw;
  logic [HB-1:0] lo_unused;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    {co_raw, sum}      = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    {h_raw, lo_unused} = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
    // borrow is the inverse of the carry when subtracting
    cy = sub ? ~co_raw : co_raw;
    hc = sub ? ~h_raw  : h_raw;
    ov = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [OPW-1:0] op,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cout
);
  localparam int HB  = DW / 2;
  localparam int MSB = DW - 1;

  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  begin res = ~a;                  cout = 1'b1;   end
      OP_LSL:  begin res = {a[MSB-1:0], 1'b0};  cout = a[MSB]; end
      OP_LSR:  begin res = {1'b0, a[MSB:1]};    cout = a[0];   end
      OP_ROL:  begin res = {a[MSB-1:0], cin};   cout = a[MSB]; end
      OP_ROR:  begin res = {cin, a[MSB:1]};     cout = a[0];   end
      OP_ASR:  begin res = {a[MSB], a[MSB:1]};  cout = a[0];   end
      OP_SWAP: res = {a[HB-1:0], a[MSB:HB]};
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic [OPW-1:0] op_sel,
  input  logic           alu_en,
  input  logic           st_load,
  input  logic [7:0]     st_wdata,
  output logic [DW-1:0]  result,
  output logic           res_we,
  output logic [7:0]     status_next,
  output logic [7:0]     status_q
);
  localparam int MSB = DW - 1;

  // operand routing for the adder/subtractor
  logic [DW-1:0] as_a, as_b, as_sum;
  logic          as_sub, as_cin, as_cy, as_hc, as_ov;
  logic [DW-1:0] bo_res;
  logic          bo_cy;

  // per-operation decode
  logic use_arith, zchain, wr_ok;
  logic up_h, up_v, up_n, up_z, up_c;
  logic v_val, c_val, h_val;
  logic z_new, n_new, v_new, s_new;

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(as_a), .b(as_b), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cy(as_cy), .hc(as_hc), .ov(as_ov)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .a(op_a), .b(op_b), .op(op_sel), .cin(status_q[FL_C]),
    .res(bo_res), .cout(bo_cy)
  );

  always_comb begin
    as_a = op_a; as_b = op_b; as_sub = 1'b0; as_cin = 1'b0;
    use_arith = 1'b0; zchain = 1'b0; wr_ok = 1'b1;
    {up_h, up_v, up_n, up_z, up_c} = 5'b0;
    v_val = 1'b0; c_val = bo_cy; h_val = as_hc;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        use_arith = 1'b1;
        as_cin = (op_sel == OP_ADC) && status_q[FL_C];
        {up_h, up_v, up_n, up_z, up_c} = 5'b11111;
        v_val = as_ov; c_val = as_cy;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
        use_arith = 1'b1; as_sub = 1'b1;
        zchain = (op_sel == OP_SBC) || (op_sel == OP_CPC);
        as_cin = zchain && status_q[FL_C];
        wr_ok  = (op_sel == OP_SUB) || (op_sel == OP_SBC);
        {up_h, up_v, up_n, up_z, up_c} = 5'b11111;
        v_val = as_ov; c_val = as_cy;
      end
      OP_NEG: begin
        use_arith = 1'b1; as_sub = 1'b1;
        as_a = '0; as_b = op_a;
        {up_h, up_v, up_n, up_z, up_c} = 5'b11111;
        v_val = as_ov; c_val = as_cy;
      end
      OP_INC, OP_DEC: begin
        use_arith = 1'b1;
        as_sub = (op_sel == OP_DEC);
        as_b = {{(DW-1){1'b0}}, 1'b1};
        {up_v, up_n, up_z} = 3'b111;
        v_val = as_ov;
      end
      OP_AND, OP_OR, OP_XOR: begin
        {up_v, up_n, up_z} = 3'b111;
      end
      OP_COM: begin
        {up_v, up_n, up_z, up_c} = 4'b1111;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        {up_v, up_n, up_z, up_c} = 4'b1111;
        v_val = bo_res[MSB] ^ bo_cy;
      end
      OP_SWAP: ;
      default: wr_ok = 1'b0;
    endcase
  end

  always_comb begin
    result = use_arith ? as_sum : bo_res;
    res_we = alu_en && wr_ok;
    n_new  = result[MSB];
    z_new  = (result == '0) && (!zchain || status_q[FL_Z]);
    v_new  = up_v ? v_val : status_q[FL_V];
    s_new  = (up_n ? n_new : status_q[FL_N]) ^ v_new;
    status_next          = status_q;
    status_next[FL_H]    = up_h ? h_val : status_q[FL_H];
    status_next[FL_V]    = v_new;
    status_next[FL_N]    = up_n ? n_new : status_q[FL_N];
    status_next[FL_Z]    = up_z ? z_new : status_q[FL_Z];
    status_next[FL_C]    = up_c ? c_val : status_q[FL_C];
    status_next[FL_S]    = (up_n || up_v) ? s_new : status_q[FL_S];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (st_load) status_q <= st_wdata;
    else if (alu_en)  status_q <= status_next;
  end

  // ---------------- assertions ----------------
  assert_load_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_load |=> status_q == $past(st_wdata));

  assert_it_untouched_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !st_load) |=> status_q[7:6] == $past(status_q[7:6]));

  assert_sign_rule_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !st_load && op_sel <= OP_CPC && op_sel != OP_SWAP)
      |=> status_q[FL_S] == (status_q[FL_N] ^ status_q[FL_V]));

  assert_swap_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !st_load && op_sel == OP_SWAP) |=> $stable(status_q));

  assert_logic_vch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !st_load && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
      |=> !status_q[FL_V] && $stable(status_q[FL_C]) && $stable(status_q[FL_H]));

  assert_zero_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !st_load && (op_sel == OP_SBC || op_sel == OP_CPC) && !status_q[FL_Z])
      |=> !status_q[FL_Z]);

endmodule

// File: tb/alu8_flags_unit_tb_top.sv
module alu8_flags_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] op_a, op_b, st_wdata;
  logic [4:0] op_sel;
  logic       alu_en, st_load;
  logic [7:0] result, status_next, status_q;
  logic       res_we;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_sr;
  bit done = 0;

  always #5 clk = ~clk;

  alu8_flags_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .alu_en(alu_en), .st_load(st_load), .st_wdata(st_wdata),
    .result(result), .res_we(res_we), .status_next(status_next), .status_q(status_q)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model from the requirements: returns {we, result, status}
  function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] sr);
    logic [7:0] r;
    logic h, s, v, n, z, c, we, touch;
    int t, ci;
    h = sr[5]; s = sr[4]; v = sr[3]; n = sr[2]; z = sr[1]; c = sr[0];
    we = 1'b1; touch = 1'b1; r = a;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(c) : 0;
        t = int'(a) + int'(b) + ci; r = t[7:0]; c = t > 255;
        h = (int'(a & 8'hF) + int'(b & 8'hF) + ci) > 15;
        v = (a[7] == b[7]) && (r[7] != a[7]); z = (r == 0);
      end
      2, 3, 17, 18: begin
        ci = (op == 3 || op == 18) ? int'(c) : 0;
        t = int'(a) - int'(b) - ci; r = t[7:0]; c = t < 0;
        h = int'(a & 8'hF) < int'(b & 8'hF) + ci;
        v = (a[7] != b[7]) && (r[7] != a[7]);
        z = (op == 3 || op == 18) ? ((r == 0) && z) : (r == 0);
        we = !(op == 17 || op == 18);
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
        v = 0; z = (r == 0);
      end
      7:  begin r = 8'hFF - a; c = 1; v = 0; z = (r == 0); end
      8:  begin r = 8'h00 - a; c = (a != 0); v = (a == 8'h80);
                h = (a[3:0] != 0); z = (r == 0); end
      9:  begin r = a + 8'd1; v = (a == 8'h7F); z = (r == 0); end
      10: begin r = a - 8'd1; v = (a == 8'h80); z = (r == 0); end
      11, 12, 13, 14, 15: begin
        case (op)
          11: begin r = {a[6:0], 1'b0}; c = a[7]; end
          12: begin r = {1'b0, a[7:1]}; c = a[0]; end
          13: begin r = {a[6:0], c};    c = a[7]; end
          14: begin r = {c, a[7:1]};    c = a[0]; end
          default: begin r = {a[7], a[7:1]}; c = a[0]; end
        endcase
        v = r[7] ^ c; z = (r == 0);
      end
      16: begin r = {a[3:0], a[7:4]}; touch = 0; end
      default: begin we = 0; touch = 0; end
    endcase
    if (touch) begin n = r[7]; s = n ^ v; end
    return {we, r, sr[7:6], h, s, v, n, z, c};
  endfunction

  task automatic apply(input string req, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b);
    logic [16:0] m;
    m = model(op, a, b, exp_sr);
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; alu_en = 1'b1;
    #1;
    check({req, " result"}, result, m[15:8]);
    check({req, " res_we"}, res_we, m[16]);
    @(posedge clk); #1;
    exp_sr = m[7:0];
    check({req, " status"}, status_q, exp_sr);
    @(negedge clk); alu_en = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] v);
    @(negedge clk);
    st_load = 1'b1; st_wdata = v;
    @(posedge clk); #1;
    exp_sr = v;
    check("R2 load", status_q, v);
    @(negedge clk); st_load = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset", status_q, 8'h00);
    exp_sr = 8'h00;
  endtask

  task automatic t_hold_and_priority();
    set_sr(8'hC3);
    repeat (2) @(posedge clk); #1;
    check("R2 hold", status_q, 8'hC3);
    @(negedge clk);
    st_load = 1'b1; st_wdata = 8'h5A; alu_en = 1'b1; op_sel = 5'd0; op_a = 8'hFF; op_b = 8'h01;
    @(posedge clk); #1;
    check("R2 priority", status_q, 8'h5A);
    @(negedge clk); st_load = 1'b0; alu_en = 1'b0; exp_sr = 8'h5A;
  endtask

  task automatic t_add();
    set_sr(8'h00);
    apply("R3 add", 5'd0, 8'h0F, 8'h01);
    apply("R3 add", 5'd0, 8'h7F, 8'h01);
    apply("R3 add", 5'd0, 8'hFF, 8'h01);
    apply("R3 adc", 5'd1, 8'h10, 8'h20);
    apply("R3 adc", 5'd1, 8'h80, 8'h80);
    for (int i = 0; i < 16; i++) apply("R3 sweep", 5'(i % 2), 8'(i * 37), 8'(i * 91 + 5));
  endtask

  task automatic t_sub();
    set_sr(8'hC0);
    apply("R4 sub", 5'd2, 8'h10, 8'h01);
    apply("R4 sub", 5'd2, 8'h80, 8'h01);
    apply("R4 sub", 5'd2, 8'h00, 8'h01);
    apply("R4 sbc", 5'd3, 8'h05, 8'h05);
    for (int i = 0; i < 16; i++) apply("R4 sweep", 5'(2 + i % 2), 8'(i * 53), 8'(i * 29 + 3));
  endtask

  task automatic t_zero_chain();
    set_sr(8'h02);
    apply("R5 sbc keep", 5'd3, 8'h22, 8'h22);
    check("R5 z kept", status_q[1], 1);
    apply("R5 cpc clear", 5'd18, 8'h23, 8'h22);
    check("R5 z cleared", status_q[1], 0);
    apply("R5 cpc no set", 5'd18, 8'h22, 8'h22);
    check("R5 z stays", status_q[1], 0);
    set_sr(8'h03);
    apply("R5 sbc carry", 5'd3, 8'h01, 8'h00);
  endtask

  task automatic t_compare();
    set_sr(8'h00);
    apply("R6 cp", 5'd17, 8'h40, 8'h41);
    apply("R6 cp eq", 5'd17, 8'h40, 8'h40);
    apply("R6 cpc", 5'd18, 8'h00, 8'hFF);
  endtask

  task automatic t_logic();
    set_sr(8'h29);
    apply("R7 and", 5'd4, 8'hF0, 8'h0F);
    apply("R7 or", 5'd5, 8'h80, 8'h01);
    apply("R7 xor", 5'd6, 8'hAA, 8'h55);
  endtask

  task automatic t_incdec();
    set_sr(8'h21);
    apply("R8 inc", 5'd9, 8'h7F, 8'h00);
    apply("R8 inc", 5'd9, 8'hFF, 8'h00);
    apply("R8 dec", 5'd10, 8'h80, 8'h00);
    apply("R8 dec", 5'd10, 8'h01, 8'h00);
  endtask

  task automatic t_comneg();
    set_sr(8'h20);
    apply("R9 com", 5'd7, 8'hFF, 8'h00);
    apply("R9 com", 5'd7, 8'h12, 8'h00);
    apply("R9 neg", 5'd8, 8'h00, 8'h00);
    apply("R9 neg", 5'd8, 8'h80, 8'h00);
    apply("R9 neg", 5'd8, 8'h01, 8'h00);
    apply("R9 neg", 5'd8, 8'h10, 8'h00);
  endtask

  task automatic t_shifts();
    set_sr(8'h20);
    apply("R10 lsl", 5'd11, 8'h81, 8'h00);
    apply("R10 lsl", 5'd11, 8'h40, 8'h00);
    apply("R10 lsr", 5'd12, 8'h01, 8'h00);
    apply("R10 lsr", 5'd12, 8'hFE, 8'h00);
    set_sr(8'h01);
    apply("R11 rol", 5'd13, 8'h80, 8'h00);
    apply("R11 rol", 5'd13, 8'h55, 8'h00);
    apply("R11 ror", 5'd14, 8'h01, 8'h00);
    apply("R11 ror", 5'd14, 8'h02, 8'h00);
    apply("R12 asr", 5'd15, 8'h81, 8'h00);
    apply("R12 asr", 5'd15, 8'h7E, 8'h00);
  endtask

  task automatic t_swap_unknown();
    set_sr(8'hFF);
    apply("R13 swap", 5'd16, 8'h3C, 8'h00);
    set_sr(8'h15);
    apply("R13 swap", 5'd16, 8'hA5, 8'h00);
    apply("R1 unknown", 5'd19, 8'h9E, 8'h11);
    apply("R1 unknown", 5'd31, 8'h00, 8'hFF);
    set_sr(8'hC0);
    apply("R14 it kept", 5'd0, 8'h01, 8'h01);
    apply("R14 sign", 5'd2, 8'h80, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; alu_en = 1'b0; st_load = 1'b0; st_wdata = '0;
    op_a = '0; op_b = '0; op_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_and_priority();
    t_add();
    t_sub();
    t_zero_chain();
    t_compare();
    t_logic();
    t_incdec();
    t_comneg();
    t_shifts();
    t_swap_unknown();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule